// File: doc/BRIEF.md
# Multi-format audio serial receiver

This block turns a stereo audio bit stream into parallel sample words. It takes a bit clock, a frame (left/right) clock and a data line, all asynchronous to the system clock. It brings each line into the system clock domain through a synchroniser and detects the rising bit-clock edges there. On each of those edges it takes one data bit. The data is two's complement and arrives most significant bit first.

A 3-bit format selector picks the framing. The choices are 16-bit, 20-bit and 24-bit right-aligned (LSB-justified) slots, a 24-bit left-aligned (MSB-justified) slot, and the I2S framing, which starts one bit late. One shared slot counter, reset at every frame-clock transition, decides which bits belong to the word in every format. Both channel words are delivered together with a single-cycle valid pulse once per frame. Right-aligned words are sign-extended to the output width. Left-aligned words are placed at the top of the output word.

Top module: `audio_serial_rx`

## Requirements
- R1: Data and frame-clock levels are taken at rising bit-clock edges only. The sender changes both lines on falling bit-clock edges.
- R2: Format code 000: the word is the last 16 bits before a frame-clock transition, sign-extended to DATA_W bits. Earlier bits of the half-frame are ignored.
- R3: Format code 001: the word is the last 20 bits before a frame-clock transition, sign-extended to DATA_W bits.
- R4: Format code 010: the first 24 bits after a frame-clock transition form the word, placed in the top 24 bits of the output with the low DATA_W-24 bits zero. Later bits are ignored. 16-bit and 20-bit words sent with zero-filled low bits come out unchanged.
- R5: Format code 011 (I2S): the first bit after a frame-clock transition is ignored and the next 24 bits form the word, top-aligned as in R4. The left channel is frame clock low.
- R6: Format code 100: the word is the last 24 bits before a frame-clock transition, sign-extended to DATA_W bits.
- R7: In codes 000, 001, 010 and 100, the half-frame with frame clock high is the left channel.
- R8: word_valid is a single-cycle pulse issued once per frame, after the right-channel word ends, which is at the first bit of the next frame. left_word and right_word change only in that cycle and otherwise hold.
- R9: Codes 101, 110 and 111 raise test_mode and produce no word_valid. Codes 000 to 100 keep test_mode low.
- R10: After reset the outputs are zero and word_valid is low. Bits before the first frame-clock transition, and a right half-frame not preceded by a complete left half-frame, produce no word.
- R11: Half-frames of 16, 20 and 24 bit clocks (32, 40 and 48 per frame) are enough for codes 000, 001 and 010/100 respectively, as are 32 bit clocks per half-frame in every mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_clk | input | 1 | Serial bit clock, asynchronous |
| frame_clk | input | 1 | Left/right frame clock, asynchronous |
| ser_data | input | 1 | Serial data, MSB first |
| fmt_sel | input | 3 | Framing format code |
| left_word | output | DATA_W | Left channel sample |
| right_word | output | DATA_W | Right channel sample |
| word_valid | output | 1 | One-cycle pulse: both words updated |
| test_mode | output | 1 | Reserved/test format selected |

## Verification
The bench builds the block with DATA_W of 28, three synchroniser stages and a 6-bit slot counter. The 28-bit width enables the padded variant of the word aligner. With it, a sign-extended right-aligned word can be told apart from a zero-padded left-aligned word in the four extra bits, which DATA_W of 24 would hide. Three synchroniser stages against an 8-cycle bit clock keep the sampling point close to the opposite bit-clock edge. With these values, the minimum bit-clock frames for each mode and the junk bits outside each slot can be checked.

// File: rtl/asrx_pkg.sv
package asrx_pkg;
   typedef enum logic [2:0] {
      FMT_LSB16 = 3'd0,
      FMT_LSB20 = 3'd1,
      FMT_MSB24 = 3'd2,
      FMT_I2S   = 3'd3,
      FMT_LSB24 = 3'd4,
      FMT_TEST  = 3'd5,
      FMT_RSV6  = 3'd6,
      FMT_RSV7  = 3'd7
   } fmt_e;

   localparam int SLOT_W = 24;
endpackage

// File: rtl/asrx_line_sync.sv
module asrx_line_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_in,
   output logic level
);
   if (STAGES < 2) begin : g_bad_stages
      $error("asrx_line_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], line_in};
   end

   assign level = chain[STAGES-1];
endmodule

// File: rtl/asrx_word_align.sv
module asrx_word_align
   import asrx_pkg::*;
#(
   parameter int DATA_W = 24
) (
   input  fmt_e              fmt,
   input  logic [SLOT_W-1:0] slot,
   output logic [DATA_W-1:0] word
);
   localparam int PAD = DATA_W - SLOT_W;

   if (PAD < 0) begin : g_bad_width
      $error("asrx_word_align: DATA_W must be at least SLOT_W");
   end

   logic [SLOT_W-1:0] ext;

   always_comb begin
      case (fmt)
         FMT_LSB16: ext = {{(SLOT_W-16){slot[15]}}, slot[15:0]};
         FMT_LSB20: ext = {{(SLOT_W-20){slot[19]}}, slot[19:0]};
         default:   ext = slot;
      endcase
   end

   if (PAD == 0) begin : g_exact
      assign word = ext;
   end else begin : g_padded
      logic right_aligned;
      assign right_aligned = (fmt == FMT_LSB16) || (fmt == FMT_LSB20) || (fmt == FMT_LSB24);
      assign word = right_aligned ? {{PAD{ext[SLOT_W-1]}}, ext} : {ext, {PAD{1'b0}}};
   end
endmodule

// File: rtl/audio_serial_rx.sv
module audio_serial_rx
   import asrx_pkg::*;
#(
   parameter int DATA_W      = 24,
   parameter int SYNC_STAGES = 2,
   parameter int CNT_W       = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_clk,
   input  logic              frame_clk,
   input  logic              ser_data,
   input  logic [2:0]        fmt_sel,
   output logic [DATA_W-1:0] left_word,
   output logic [DATA_W-1:0] right_word,
   output logic              word_valid,
   output logic              test_mode
);
   localparam logic [CNT_W-1:0] IDX_SAT  = {CNT_W{1'b1}};
   localparam logic [CNT_W-1:0] IDX_SLOT = CNT_W'(SLOT_W);

   if (CNT_W < 5) begin : g_bad_cnt
      $error("audio_serial_rx: CNT_W must reach index 25");
   end
   if (DATA_W < SLOT_W) begin : g_bad_data
      $error("audio_serial_rx: DATA_W must be at least 24");
   end

   // ---------------- line synchronisers ----------------
   logic [2:0] raw_lines, sync_lines;
   assign raw_lines = {ser_data, frame_clk, bit_clk};

   for (genvar i = 0; i < 3; i++) begin : g_sync
      asrx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
         .clk    (clk),
         .rst_n  (rst_n),
         .line_in(raw_lines[i]),
         .level  (sync_lines[i])
      );
   end

   logic bck_lvl, lr_lvl, sd_lvl;
   assign bck_lvl = sync_lines[0];
   assign lr_lvl  = sync_lines[1];
   assign sd_lvl  = sync_lines[2];

   // ---------------- state ----------------
   fmt_e              fmt_q;
   logic              bck_last, lr_last, primed, armed, have_left;
   logic [CNT_W-1:0]  slot_idx;
   logic [SLOT_W-1:0] shreg;
   logic [DATA_W-1:0] left_hold;

   logic              tick, boundary, shift_en, ended_left, supported;
   logic [CNT_W-1:0]  idx_now;
   logic [DATA_W-1:0] aligned;

   assign tick     = bck_lvl & ~bck_last;
   assign boundary = tick & primed & (lr_lvl != lr_last);

   always_comb begin
      if (boundary)                idx_now = '0;
      else if (slot_idx == IDX_SAT) idx_now = slot_idx;
      else                          idx_now = slot_idx + 1'b1;
   end

   always_comb begin
      case (fmt_q)
         FMT_MSB24: shift_en = (idx_now < IDX_SLOT);
         FMT_I2S:   shift_en = (idx_now != '0) && (idx_now <= IDX_SLOT);
         default:   shift_en = 1'b1;
      endcase
   end

   assign ended_left = (fmt_q == FMT_I2S) ? ~lr_last : lr_last;
   assign supported  = (fmt_q <= FMT_LSB24);

   asrx_word_align #(.DATA_W(DATA_W)) u_align (
      .fmt (fmt_q),
      .slot(shreg),
      .word(aligned)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fmt_q      <= FMT_LSB16;
         test_mode  <= 1'b0;
         bck_last   <= 1'b0;
         lr_last    <= 1'b0;
         primed     <= 1'b0;
         armed      <= 1'b0;
         have_left  <= 1'b0;
         slot_idx   <= '0;
         shreg      <= '0;
         left_hold  <= '0;
         left_word  <= '0;
         right_word <= '0;
         word_valid <= 1'b0;
      end else begin
         fmt_q      <= fmt_e'(fmt_sel);
         test_mode  <= (fmt_sel > 3'd4);
         bck_last   <= bck_lvl;
         word_valid <= 1'b0;
         if (tick) begin
            primed   <= 1'b1;
            lr_last  <= lr_lvl;
            slot_idx <= idx_now;
            if (shift_en) shreg <= {shreg[SLOT_W-2:0], sd_lvl};
            if (boundary) begin
               armed <= 1'b1;
               if (armed && supported) begin
                  if (ended_left) begin
                     left_hold <= aligned;
                     have_left <= 1'b1;
                  end else if (have_left) begin
                     left_word  <= left_hold;
                     right_word <= aligned;
                     word_valid <= 1'b1;
                     have_left  <= 1'b0;
                  end
               end else begin
                  have_left <= 1'b0;
               end
            end
         end
      end
   end

   // ---------------- assertions ----------------
   // R8
   valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      word_valid |=> !word_valid);

   // R8
   word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !word_valid |-> ($stable(left_word) && $stable(right_word)));

   // R9
   test_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (test_mode && $past(test_mode)) |-> !word_valid);

   // R2
   sext16_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (word_valid && $past(fmt_q) == FMT_LSB16) |->
         ((left_word[DATA_W-1:15] == '0) || (left_word[DATA_W-1:15] == '1)));

   // R10
   armed_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(armed) |-> !word_valid);
endmodule

// File: tb/audio_serial_rx_tb.sv
module audio_serial_rx_tb;
   localparam int DW = 28;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bck = 1'b0, lrck = 1'b0, sd = 1'b0;
   logic [2:0]    fmt = 3'd0;
   logic [DW-1:0] lw_o, rw_o;
   logic          valid_o, test_o;

   int checks = 0, fails = 0, valid_seen = 0;
   bit done = 0;

   logic [DW-1:0] exp_l[$], exp_r[$];
   string         tag_q[$];

   always #10 clk = ~clk;

   audio_serial_rx #(.DATA_W(DW), .SYNC_STAGES(3), .CNT_W(6)) u_dut (
      .clk(clk), .rst_n(rst_n), .bit_clk(bck), .frame_clk(lrck), .ser_data(sd),
      .fmt_sel(fmt), .left_word(lw_o), .right_word(rw_o),
      .word_valid(valid_o), .test_mode(test_o)
   );

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   function automatic logic [DW-1:0] expect_word(input logic [2:0] f, input logic [23:0] w);
      case (f)
         3'd0:    return {{(DW-16){w[15]}}, w[15:0]};
         3'd1:    return {{(DW-20){w[19]}}, w[19:0]};
         3'd4:    return {{(DW-24){w[23]}}, w};
         default: return {w, {(DW-24){1'b0}}};
      endcase
   endfunction

   function automatic logic half_bit(input logic [2:0] f, input int b, input logic [23:0] w, input int i);
      int n;
      logic junk;
      junk = i[0] ^ i[1];
      n = (f == 3'd0) ? 16 : (f == 3'd1) ? 20 : 24;
      case (f)
         3'd2:    return (i < 24) ? w[23-i] : junk;
         3'd3:    return (i >= 1 && i <= 24) ? w[24-i] : junk;
         default: return (i >= b - n) ? w[n-1-(i-(b-n))] : junk;
      endcase
   endfunction

   // R1: every change of data and frame clock happens with the bit clock low
   task automatic drive_slot(input logic lr, input logic d);
      @(negedge clk);
      bck = 1'b0; lrck = lr; sd = d;
      repeat (3) @(negedge clk);
      bck = 1'b1;
      repeat (4) @(negedge clk);
   endtask

   task automatic send_half(input logic [2:0] f, input int b, input logic [23:0] w, input logic lr);
      for (int i = 0; i < b; i++) drive_slot(lr, half_bit(f, b, w, i));
   endtask

   task automatic send_frame(input logic [2:0] f, input int b, input logic [23:0] lw,
                             input logic [23:0] rw, input string tag, input bit expect_out);
      logic left_lvl;
      left_lvl = (f == 3'd3) ? 1'b0 : 1'b1;
      if (expect_out) begin
         exp_l.push_back(expect_word(f, lw));
         exp_r.push_back(expect_word(f, rw));
         tag_q.push_back(tag);
      end
      send_half(f, b, lw, left_lvl);
      send_half(f, b, rw, ~left_lvl);
   endtask

   task automatic do_reset(input logic [2:0] f);
      @(negedge clk);
      rst_n = 1'b0; bck = 1'b0; lrck = 1'b0; sd = 1'b0; fmt = f;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
   endtask

   // R10: start in the middle of a left half, then a full right half: no word expected
   task automatic preamble(input logic [2:0] f);
      logic left_lvl;
      left_lvl = (f == 3'd3) ? 1'b0 : 1'b1;
      for (int i = 0; i < 5; i++) drive_slot(left_lvl, i[0]);
      send_half(f, 32, 24'hF0F0F0, ~left_lvl);
   endtask

   task automatic flush_and_check(input logic [2:0] f, input string tag);
      logic left_lvl;
      left_lvl = (f == 3'd3) ? 1'b0 : 1'b1;
      drive_slot(left_lvl, 1'b0);
      drive_slot(left_lvl, 1'b0);
      repeat (20) @(negedge clk);
      chk(exp_l.size() == 0, tag, exp_l.size(), 0);
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && valid_o) begin
         valid_seen++;
         if (exp_l.size() == 0) begin
            chk(1'b0, "R8 unexpected word_valid", 32'(lw_o), 0);
         end else begin
            logic [DW-1:0] el, er;
            string t;
            el = exp_l.pop_front();
            er = exp_r.pop_front();
            t  = tag_q.pop_front();
            chk(lw_o == el, {t, " left"},  32'(lw_o), 32'(el));
            chk(rw_o == er, {t, " right"}, 32'(rw_o), 32'(er));
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      int snap;
      do_reset(3'd0);
      // R10 reset state
      chk(lw_o == '0 && rw_o == '0, "R10 reset words", 32'(lw_o), 0);
      chk(valid_o == 1'b0, "R10 reset valid", 32'(valid_o), 0);
      // R9 supported code keeps flag low
      chk(test_o == 1'b0, "R9 test_mode low", 32'(test_o), 0);

      // mode 000
      preamble(3'd0);
      send_frame(3'd0, 32, 24'h008001, 24'h007FFF, "R2 R7", 1);
      send_frame(3'd0, 16, 24'hFF1234, 24'h00FFFF, "R2 R11", 1);
      flush_and_check(3'd0, "R8 mode0 drained");

      // mode 001
      do_reset(3'd1);
      preamble(3'd1);
      send_frame(3'd1, 32, 24'h080000, 24'h07FFFF, "R3 R7", 1);
      send_frame(3'd1, 20, 24'h0A5A5A, 24'h0F0F0F, "R3 R11", 1);
      flush_and_check(3'd1, "R8 mode1 drained");

      // mode 010
      do_reset(3'd2);
      preamble(3'd2);
      send_frame(3'd2, 32, 24'h800000, 24'h7FFFFF, "R4 R7", 1);
      send_frame(3'd2, 24, 24'hABCD00, 24'h123450, "R4 R11", 1);
      flush_and_check(3'd2, "R8 mode2 drained");

      // mode 011
      do_reset(3'd3);
      preamble(3'd3);
      send_frame(3'd3, 32, 24'hC35A96, 24'h3CA569, "R5", 1);
      send_frame(3'd3, 32, 24'h000001, 24'hFFFFFE, "R5 R1", 1);
      flush_and_check(3'd3, "R8 mode3 drained");

      // mode 100
      do_reset(3'd4);
      chk(test_o == 1'b0, "R9 test_mode low mode4", 32'(test_o), 0);
      preamble(3'd4);
      send_frame(3'd4, 32, 24'h800001, 24'h7FFFFE, "R6 R7", 1);
      send_frame(3'd4, 24, 24'h5A5A5A, 24'hA5A5A5, "R6 R11", 1);
      flush_and_check(3'd4, "R8 mode4 drained");

      // test code 101: flag high, no words
      do_reset(3'd5);
      repeat (3) @(negedge clk);
      chk(test_o == 1'b1, "R9 test_mode high", 32'(test_o), 1);
      snap = valid_seen;
      preamble(3'd5);
      send_frame(3'd5, 32, 24'h123456, 24'h654321, "R9", 0);
      send_frame(3'd5, 32, 24'h111111, 24'h222222, "R9", 0);
      drive_slot(1'b1, 1'b0);
      repeat (20) @(negedge clk);
      chk(valid_seen == snap, "R9 no valid in test code", 32'(valid_seen - snap), 0);

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule